// File: doc/BRIEF.md
# Programmable Interval Timer Channel

This block is one channel of an interval timer. It counts down on a slow tick strobe, such as a 1 MHz enable derived elsewhere, and raises a level interrupt when the count runs out. Software writes a single control word to start it. That word holds an enable flag, a periodic/one-shot selector and a 29-bit load value N. The channel expires after N+1 ticks. In periodic mode it reloads N and keeps running. In one-shot mode it disables itself. A second register reports the live count and the pending flag. Writing a one to the clear bit of that register drops the interrupt.

Register access is a plain single-cycle strobe interface, with no valid/ready handshake. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational while `bus_sel` is high and `bus_wr` is low, and reads have no side effects. The block never applies back-pressure.

Several copies of the channel can share one address space. Each copy takes a channel index, and its register pair sits 8 bytes above the previous channel's pair. The control word is at the pair's base address and the status word is at base + 4.

Top module: `tmr_channel`

## Requirements
- R1: After reset `irq` is low, and reads of both the control and the status register return zero.
- R2: The control register decodes only at BANK_BASE + 8*CHAN_IDX, and the status register only at that address + 4. A write to any other address changes nothing, and a read of any other address returns zero.
- R3: Control word layout: bit 31 is enable, bit 30 selects periodic mode (1) or one-shot mode (0), and bits 28:0 hold N. Bit 29 is not stored and reads back as 0.
- R4: Every control write reloads the count with the new N. A tick in the same cycle as a control write is ignored.
- R5: While the channel is enabled, expiry happens on the (N+1)-th tick after the load. N = 0 expires on the first tick.
- R6: In periodic mode, expiry reloads N, the enable bit stays set, and the channel keeps expiring every N+1 ticks.
- R7: In one-shot mode, expiry clears the enable bit and leaves the count at 0. Later ticks cause no further expiry.
- R8: Writing 0 to the control register stops the channel. While it is disabled, ticks leave the count unchanged.
- R9: The status register reads the current count in bits 28:0 and the pending flag in bit 30. All other bits read 0.
- R10: Writing the status register with bit 30 set clears the pending flag. If bit 30 is clear, the write has no effect. If an expiry happens in the same cycle as a clear, the flag stays set.
- R11: `irq` is an active-high level. It follows the pending flag and stays high until the flag is cleared.
- R12: The largest load value, 0x1FFFFFFF, is accepted and counts down from that value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle count strobe |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (0 when not selected or not decoded) |
| irq | output | 1 | Active-high level interrupt |

## Verification
The count is driven with short and long tick runs against small load values, in both modes. This separates three cases: a run that stops just before expiry, a run that expires exactly on tick N+1, and a run that overshoots. An overshoot in one-shot mode must hold at zero, while in periodic mode it must wrap to a known residue after several reloads. Loads of zero and of the largest 29-bit value cover the two ends of the count field. A load with the enable bit clear shows that ticks leave a stopped channel unchanged. Directed cases make a control write or a clear coincide with a tick, which settles the priority in each collision. A write to the neighbouring channel's address shows that the decode is exact.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 29;
  localparam int EN_BIT   = 31;
  localparam int MODE_BIT = 30;
  localparam int CLR_BIT  = 30;
  localparam int PEND_BIT = 30;

  typedef struct packed {
    logic             run;
    logic             periodic;
    logic [CNT_W-1:0] load;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int ADDR_W      = 12,
  parameter int BANK_BASE   = 0,
  parameter int CHAN_IDX    = 1,
  parameter int BANK_STRIDE = 8,
  parameter int STAT_OFS    = 4
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  tmr_ctrl_t         ctrl_q,
  input  logic [CNT_W-1:0]  count,
  input  logic              pend,
  output logic              ctrl_wr,
  output tmr_ctrl_t         ctrl_new,
  output logic              clr_req,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BANK_BASE + CHAN_IDX * BANK_STRIDE);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(BANK_BASE + CHAN_IDX * BANK_STRIDE + STAT_OFS);

  logic hit_ctrl, hit_stat;

  always_comb begin
    hit_ctrl = bus_sel && (bus_addr == CTRL_ADDR);
    hit_stat = bus_sel && (bus_addr == STAT_ADDR);
    ctrl_wr  = hit_ctrl && bus_wr;
    clr_req  = hit_stat && bus_wr && bus_wdata[CLR_BIT];
    ctrl_new.run      = bus_wdata[EN_BIT];
    ctrl_new.periodic = bus_wdata[MODE_BIT];
    ctrl_new.load     = bus_wdata[CNT_W-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl && !bus_wr) begin
      bus_rdata[EN_BIT]      = ctrl_q.run;
      bus_rdata[MODE_BIT]    = ctrl_q.periodic;
      bus_rdata[CNT_W-1:0]   = ctrl_q.load;
    end else if (hit_stat && !bus_wr) begin
      bus_rdata[PEND_BIT]    = pend;
      bus_rdata[CNT_W-1:0]   = count;
    end
  end

  // R2: the two register strobes never fire together
  always_comb begin
    a_r2_one_target: assert (!(hit_ctrl && hit_stat));
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             ctrl_wr,
  input  tmr_ctrl_t        ctrl_new,
  output tmr_ctrl_t        ctrl_q,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  logic at_zero;

  always_comb begin
    at_zero = (count == '0);
    expire  = ctrl_q.run && tick && at_zero && !ctrl_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      count  <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= ctrl_new;
      count  <= ctrl_new.load;
    end else if (ctrl_q.run && tick) begin
      if (at_zero) begin
        if (ctrl_q.periodic) count <= ctrl_q.load;
        else                 ctrl_q.run <= 1'b0;
      end else begin
        count <= count - 1'b1;
      end
    end
  end

  // R4: a control write sets the count to the written load value
  a_r4_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> count == $past(ctrl_new.load));
  // R6: periodic expiry reloads and stays enabled
  a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && ctrl_q.periodic) |=> (count == $past(ctrl_q.load)) && ctrl_q.run);
  // R7: one-shot expiry turns the channel off
  a_r7_oneshot_off: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !ctrl_q.periodic) |=> !ctrl_q.run && (count == '0));
  // R8: a stopped channel holds its count
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.run && !ctrl_wr) |=> $stable(count));
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr_req,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend <= 1'b0;
    else if (expire)  pend <= 1'b1;
    else if (clr_req) pend <= 1'b0;
  end

  // R10: expiry wins over a clear in the same cycle
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend);
  // R10: a clear with no expiry drops the flag
  a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !expire) |=> !pend);
  // R11: the level only rises because of an expiry
  a_r11_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(expire));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int BANK_BASE = 0,
  parameter int CHAN_IDX  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  tmr_ctrl_t        ctrl_q, ctrl_new;
  logic [CNT_W-1:0] count;
  logic             ctrl_wr, clr_req, expire, pend;

  tmr_regs #(
    .ADDR_W(ADDR_W), .BANK_BASE(BANK_BASE), .CHAN_IDX(CHAN_IDX),
    .BANK_STRIDE(8), .STAT_OFS(4)
  ) u_regs (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctrl_q(ctrl_q), .count(count), .pend(pend),
    .ctrl_wr(ctrl_wr), .ctrl_new(ctrl_new), .clr_req(clr_req),
    .bus_rdata(bus_rdata)
  );

  tmr_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl_wr(ctrl_wr),
    .ctrl_new(ctrl_new), .ctrl_q(ctrl_q), .count(count), .expire(expire)
  );

  tmr_irq u_irq (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr_req(clr_req), .pend(pend)
  );

  assign irq = pend;
endmodule

// File: tb/sim_tmr_channel.sv
`timescale 1ns/1ps
module sim_tmr_channel;
  localparam logic [11:0] CTRL_A = 12'h008;
  localparam logic [11:0] STAT_A = 12'h00C;
  localparam logic [31:0] CLR    = 32'h4000_0000;
  localparam int NV = 9;

  // vector table: control word, ticks, expected count, pending, enable
  localparam logic [31:0] V_CTRL [NV] = '{32'h8000_0005, 32'h8000_0005, 32'h8000_0005,
    32'h8000_0000, 32'hC000_0003, 32'hC000_0003, 32'hC000_0002, 32'hDFFF_FFFF, 32'h0000_0004};
  localparam int          V_TICK [NV] = '{3, 6, 8, 1, 4, 6, 9, 2, 3};
  localparam logic [28:0] V_CNT  [NV] = '{29'd2, 29'd0, 29'd0, 29'd0, 29'd3, 29'd1, 29'd2,
    29'h1FFF_FFFD, 29'd4};
  localparam logic        V_PEND [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic        V_EN   [NV] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};

  logic clk = 0, rst_n = 0, tick = 0, bus_sel = 0, bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_channel u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, logic t);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; tick = t;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; tick = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(CTRL_A, v); check("R1 ctrl", v, 32'h0);
    rd(STAT_A, v); check("R1 stat", v, 32'h0);
    // R2 neighbour channel address ignored
    wr(12'h000, 32'h8000_0005, 0);
    rd(CTRL_A, v); check("R2 no write", v, 32'h0);
    rd(12'h000, v); check("R2 unmapped read", v, 32'h0);

    // table walk: R5 R6 R7 R9 R11 R12
    for (int k = 0; k < NV; k++) begin
      wr(CTRL_A, V_CTRL[k], 0);
      wr(STAT_A, CLR, 0);
      ticks(V_TICK[k]);
      rd(STAT_A, v);
      check($sformatf("R5/R6/R7/R9/R12 vec%0d stat", k), v, {1'b0, V_PEND[k], 1'b0, V_CNT[k]});
      rd(CTRL_A, v);
      check($sformatf("R6/R7 vec%0d ctrl", k), v, {V_EN[k], V_CTRL[k][30:0]});
      check($sformatf("R11 vec%0d irq", k), {31'b0, irq}, {31'b0, V_PEND[k]});
    end

    // R3 bit 29 not stored
    wr(CTRL_A, 32'hE000_0007, 0);
    rd(CTRL_A, v); check("R3 layout", v, 32'hC000_0007);

    // R4 control write beats a same-cycle tick
    wr(CTRL_A, 32'hC000_0010, 0);
    ticks(4);
    wr(CTRL_A, 32'h8000_0020, 1);
    rd(STAT_A, v); check("R4 restart", v & 32'h1FFF_FFFF, 32'h20);

    // R8 stop
    wr(STAT_A, CLR, 0);
    wr(CTRL_A, 32'h8000_0010, 0);
    ticks(3);
    wr(CTRL_A, 32'h0, 0);
    ticks(5);
    rd(STAT_A, v); check("R8 stopped", v, 32'h0);
    rd(CTRL_A, v); check("R8 ctrl", v, 32'h0);

    // R7 no further expiry after one-shot
    wr(CTRL_A, 32'h8000_0001, 0);
    ticks(2);
    check("R7 first expiry irq", {31'b0, irq}, 32'h1);
    wr(STAT_A, CLR, 0);
    ticks(5);
    rd(STAT_A, v); check("R7 no re-expiry", v, 32'h0);

    // R10 clear rules
    wr(CTRL_A, 32'h8000_0000, 0);
    ticks(1);
    wr(STAT_A, 32'hBFFF_FFFF, 0);
    check("R10 bit30 low no clear", {31'b0, irq}, 32'h1);
    wr(STAT_A, CLR, 0);
    check("R10 clear", {31'b0, irq}, 32'h0);
    check("R11 irq low after clear", {31'b0, irq}, 32'h0);
    wr(CTRL_A, 32'hC000_0000, 0);
    ticks(1);
    wr(STAT_A, CLR, 1);
    rd(STAT_A, v); check("R10 expiry wins", v, 32'h4000_0000);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule